// File: doc/BRIEF.md
# Debug Slave Controller with Step Control

This block is the debug endpoint that sits inside one partition of a multi-device emulation of a processor. A master broadcasts commands on a shared bus. Each command word holds a command code, a chip identifier, a debug-module identifier and a register index. Write data travels on a separate input bus. The slave whose chip identifier matches answers reads on its data-out bus and drives zero at all other times, so the master can OR the buses of all slaves together.

While the debug-mode input is high, the target processor is frozen: its clock enable stays low. A write to the step register tells the slave to release the clock enable a fixed number of times, once per core period, and then freeze the target again. The block runs on one fast clock. It divides that clock into a core-clock enable and a separate DMA-clock enable.

Top module: `dbg_slave`

## Requirements
- R1: After reset, `dbg_dout` is zero, `core_en` is low, the step count is zero and every general register reads zero.
- R2: While `debug_mode` is low, `core_en` pulses for one cycle out of every CORE_DIV cycles. The first pulse comes CORE_DIV cycles after reset.
- R3: While `debug_mode` is high and no steps are pending, `core_en` stays low.
- R4: The command code sits in `dbg_addr[AW-1:AW-2]`, where 01 means read and 10 means write. The chip identifier sits in the CW bits below the command code, the module identifier in the MW bits below that, and the register index in the low RW bits. A write to module GP_MOD stores `dbg_din` in the indexed register. A read returns that register on `dbg_dout` in the cycle after the command.
- R5: `dbg_dout` is zero in every cycle that does not directly follow a read addressed to CHIP_ID. A write addressed to another chip identifier changes no register of this slave.
- R6: Commands issued while `debug_mode` is low are ignored.
- R7: Writing N to register 0 of module STEP_MOD gives exactly N `core_en` pulses, one per core period. After the last pulse the target stays frozen.
- R8: Register 1 of module STEP_MOD reads back with bit 0 set while steps remain and all other bits zero. Register 0 of that module reads back the remaining step count.
- R9: `dma_en` pulses for one cycle out of every DMA_DIV cycles, whatever the state of `debug_mode`.
- R10: Writes to a module other than GP_MOD and STEP_MOD are discarded, and reads from such a module return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast emulation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| debug_mode | input | 1 | Freezes the target and enables command handling |
| dbg_addr | input | AW | Command code, chip identifier, module identifier and register index |
| dbg_din | input | DW | Write data from the master |
| dbg_dout | output | DW | Read data to the master; zero unless answering a read |
| core_en | output | 1 | Single-cycle core clock enable |
| dma_en | output | 1 | Single-cycle DMA clock enable |

## Verification
The bench targets the step count. A design with an off-by-one error in the countdown gives N-1 or N+1 pulses. A design that decrements outside debug mode loses steps. It also checks that a step write made while another count is still pending replaces that count. A design that is careless with chip decoding drives the shared read bus when another slave is addressed, or accepts writes meant for another chip. A design that does not gate commands on debug mode lets software alter registers while the target is running. The bench also checks that the DMA enable keeps its period while the core is frozen.

// File: rtl/dbg_slave.sv
module dbg_slave #(
  parameter int CHIP_ID  = 5,
  parameter int CW       = 4,
  parameter int MW       = 3,
  parameter int RW       = 3,
  parameter int DW       = 16,
  parameter int GP_MOD   = 0,
  parameter int STEP_MOD = 7,
  parameter int CORE_DIV = 8,
  parameter int DMA_DIV  = 13,
  localparam int AW      = 2 + CW + MW + RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          debug_mode,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_din,
  output logic [DW-1:0] dbg_dout,
  output logic          core_en,
  output logic          dma_en
);
  localparam int NREGS = 1 << RW;
  localparam int CDW = $clog2(CORE_DIV);
  localparam int DDW = $clog2(DMA_DIV);

  logic [1:0]    cmd;
  logic [CW-1:0] chip;
  logic [MW-1:0] mod;
  logic [RW-1:0] rsel;
  assign cmd  = dbg_addr[AW-1 -: 2];
  assign chip = dbg_addr[RW+MW +: CW];
  assign mod  = dbg_addr[RW +: MW];
  assign rsel = dbg_addr[RW-1:0];

  logic hit, rd_hit, wr_hit, gp_sel, st_sel, step_wr;
  assign hit     = debug_mode && (chip == CW'(CHIP_ID));
  assign rd_hit  = hit && (cmd == 2'b01);
  assign wr_hit  = hit && (cmd == 2'b10);
  assign gp_sel  = (mod == MW'(GP_MOD));
  assign st_sel  = (mod == MW'(STEP_MOD));
  assign step_wr = wr_hit && st_sel && (rsel == '0);

  logic [CDW-1:0] core_cnt;
  logic [DDW-1:0] dma_cnt;
  logic [DW-1:0]  steps;
  logic [DW-1:0]  regs [NREGS];
  logic           core_tick;

  assign core_tick = (core_cnt == CDW'(CORE_DIV - 1));
  assign core_en   = core_tick && (!debug_mode || steps != '0);
  assign dma_en    = (dma_cnt == DDW'(DMA_DIV - 1));

  logic [DW-1:0] rdata;
  always_comb begin
    rdata = '0;
    if (gp_sel)
      rdata = regs[rsel];
    else if (st_sel && rsel == RW'(0))
      rdata = steps;
    else if (st_sel && rsel == RW'(1))
      rdata = DW'(steps != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_cnt <= '0;
      dma_cnt  <= '0;
      steps    <= '0;
      dbg_dout <= '0;
    end else begin
      core_cnt <= core_tick ? '0 : core_cnt + 1'b1;
      dma_cnt  <= dma_en ? '0 : dma_cnt + 1'b1;
      dbg_dout <= rd_hit ? rdata : '0;
      if (step_wr)
        steps <= dbg_din;
      else if (core_tick && debug_mode && steps != '0)
        steps <= steps - 1'b1;
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_hit && gp_sel && rsel == RW'(i))
        regs[i] <= dbg_din;
    end
  end
endmodule

module dbg_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          debug_mode,
  input logic          core_en,
  input logic          rd_hit,
  input logic          step_wr,
  input logic [DW-1:0] steps,
  input logic [DW-1:0] dbg_dout
);
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode && steps == '0) |-> !core_en);

  p_step_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && debug_mode && !step_wr) |=> (steps == $past(steps) - 1'b1));

  p_dout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (dbg_dout == '0));

  p_run_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !debug_mode |=> $stable(steps));

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> !core_en);
endmodule

bind dbg_slave dbg_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode), .core_en(core_en),
  .rd_hit(rd_hit), .step_wr(step_wr), .steps(steps), .dbg_dout(dbg_dout)
);

// File: tb/dbg_slave_tb.sv
module dbg_slave_tb;
  localparam int CID = 5, CW = 4, MW = 3, RW = 3, DW = 16;
  localparam int CD = 8, DD = 13;
  localparam int AW = 2 + CW + MW + RW;

  logic clk = 0, rst_n = 0, debug_mode = 0;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_din = '0;
  logic [DW-1:0] dbg_dout;
  logic core_en, dma_en;

  always #2 clk = ~clk;

  dbg_slave u_dut (.clk(clk), .rst_n(rst_n), .debug_mode(debug_mode),
    .dbg_addr(dbg_addr), .dbg_din(dbg_din), .dbg_dout(dbg_dout),
    .core_en(core_en), .dma_en(dma_en));

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  // reference model
  int m_core, m_dma, m_steps, m_dout;
  int m_regs[8];

  always @(posedge clk) begin
    int c, ch, md, rg, rv;
    bit h;
    if (!rst_n) begin
      m_core = 0; m_dma = 0; m_steps = 0; m_dout = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      c = dbg_addr[AW-1 -: 2]; ch = dbg_addr[RW+MW +: CW];
      md = dbg_addr[RW +: MW]; rg = dbg_addr[RW-1:0];
      h = debug_mode && ch == CID;
      rv = 0;
      if (md == 0) rv = m_regs[rg];
      else if (md == 7 && rg == 0) rv = m_steps;
      else if (md == 7 && rg == 1) rv = (m_steps > 0) ? 1 : 0;
      m_dout = (h && c == 1) ? rv : 0;
      if (h && c == 2 && md == 7 && rg == 0) m_steps = dbg_din;
      else if (m_core == CD - 1 && debug_mode && m_steps > 0) m_steps--;
      if (h && c == 2 && md == 0) m_regs[rg] = dbg_din;
      m_core = (m_core + 1) % CD;
      m_dma = (m_dma + 1) % DD;
    end
  end

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  int n_core = 0, n_dma = 0;
  always @(negedge clk) if (rst_n && !done) begin
    if (core_en) n_core++;
    if (dma_en) n_dma++;
    chk(req, core_en, (m_core == CD - 1) && (!debug_mode || m_steps > 0), "core_en model");
    chk("R9", dma_en, m_dma == DD - 1, "dma_en model");
    chk(req, dbg_dout, m_dout, "dbg_dout model");
  end

  task automatic issue(int c, int ch, int md, int rg, int d);
    @(posedge clk); #1;
    dbg_addr = {c[1:0], ch[CW-1:0], md[MW-1:0], rg[RW-1:0]};
    dbg_din = d[DW-1:0];
    @(posedge clk); #1;
    dbg_addr = '0;
  endtask

  task automatic rd(int ch, int md, int rg, output int v);
    issue(1, ch, md, rg, 0);
    @(negedge clk); v = dbg_dout;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    req = "R1";
    chk("R1", dbg_dout, 0, "dout after reset");
    chk("R1", core_en, 0, "core_en after reset");
    debug_mode = 1;
    rd(CID, 7, 0, v); chk("R1", v, 0, "step count after reset");
    rd(CID, 0, 3, v); chk("R1", v, 0, "gp reg after reset");
    debug_mode = 0;

    req = "R2"; #1; n_core = 0; n_dma = 0; idle(CD * 10);
    chk("R2", n_core, 10, "free-run pulse count");

    req = "R3"; debug_mode = 1; #1; n_core = 0; idle(CD * 6);
    chk("R3", n_core, 0, "frozen pulse count");

    req = "R4";
    issue(2, CID, 0, 2, 16'hA5C3);
    issue(2, CID, 0, 7, 16'h1234);
    rd(CID, 0, 2, v); chk("R4", v, 16'hA5C3, "reg2 readback");
    rd(CID, 0, 7, v); chk("R4", v, 16'h1234, "reg7 readback");

    req = "R5";
    issue(2, 3, 0, 2, 16'h0F0F);
    rd(3, 0, 2, v); chk("R5", v, 0, "other chip read");
    rd(CID, 0, 2, v); chk("R5", v, 16'hA5C3, "other chip write ignored");
    @(negedge clk); chk("R5", dbg_dout, 0, "dout idle");

    req = "R6";
    debug_mode = 0;
    issue(2, CID, 0, 2, 16'h7777);
    issue(2, CID, 7, 0, 9);
    debug_mode = 1;
    rd(CID, 0, 2, v); chk("R6", v, 16'hA5C3, "run-mode write ignored");
    rd(CID, 7, 0, v); chk("R6", v, 0, "run-mode step write ignored");

    req = "R10";
    issue(2, CID, 2, 1, 16'hBEEF);
    rd(CID, 2, 1, v); chk("R10", v, 0, "unmapped module read");

    req = "R7";
    issue(2, CID, 7, 0, 3);
    n_core = 0;
    req = "R8";
    rd(CID, 7, 1, v); chk("R8", v, 1, "busy while stepping");
    req = "R7";
    idle(CD * 6);
    chk("R7", n_core, 3, "three steps");
    req = "R8";
    rd(CID, 7, 1, v); chk("R8", v, 0, "idle after steps");
    rd(CID, 7, 0, v); chk("R8", v, 0, "remaining zero");

    req = "R7";
    issue(2, CID, 7, 0, 20);
    idle(CD * 2);
    issue(2, CID, 7, 0, 1);
    n_core = 0;
    idle(CD * 4);
    chk("R7", n_core, 1, "overwrite pending count");

    req = "R9"; n_dma = 0; idle(DD * 7);
    chk("R9", n_dma, 7, "dma pulses while frozen");

    debug_mode = 0; req = "R2"; idle(CD * 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule